// File: doc/BRIEF.md
# Prioritised DMA Channel Arbiter

This block chooses which of sixteen DMA channels the transfer engine serves next. A channel competes when its hardware request line is high and its bit in a local enable mask is set. Software edits that mask with byte-wide set and clear commands. Each command names one channel, names all channels, or does nothing. Each channel also holds a priority byte. The byte carries a 4-bit level and two flags. One flag lets the channel be displaced by a stronger request. The other stops the channel from displacing anyone.

A small control register selects one of two arbitration modes. In fixed mode the highest level wins. In rotating mode the search starts at the channel after the one granted last. The same register holds a halt bit, which stops all new grants, and a halt-on-error bit. A channel counts as in service from its grant until the engine pulses done. While a channel is in service, or while the engine reports busy, no ordinary grant is issued. Only a preemption can replace the channel in service. The arbiter watches the priority bank continuously for two channels that share a level. When it finds one, it raises a sticky error word that names the offending channel.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset the enable mask is all zero, the error word is zero, halt is clear, no grant is shown, and channel n holds level n with both flags clear.
- R2: A channel can be granted only while both its request line and its enable bit are set. The grant appears as a one-cycle pulse on the cycle after the arbiter samples those inputs.
- R3: With control bit 0 clear (fixed mode), the eligible channel with the numerically largest level wins. On equal levels the lower channel number wins.
- R4: With control bit 0 set (rotating mode), the winner is the first eligible channel after the last granted one, searching upward and wrapping from 15 to 0. After reset the last granted channel is taken to be 15.
- R5: No ordinary grant is issued while busy_i is high or while a channel is in service. A channel is in service from its grant until a done_i pulse.
- R6: In fixed mode only, a preemption grant (grant_valid_o and preempt_o both high) replaces the channel in service. It needs all of the following: the in-service channel has bit 7 of its priority byte set; the best eligible channel has a strictly larger level; and that channel has bit 6 clear.
- R7: If done_i arrives in the same cycle as a preemption condition, no preemption is made. The channel leaves service, and an ordinary grant may follow on the next cycle.
- R8: Enable commands use bits 3:0 to pick a channel and bit 6 to act on all channels. Bit 7 makes the command do nothing and outranks bit 6. If a set and a clear arrive together, the clear wins for any channel both name.
- R9: When any two channels hold the same level, bits 31 and 14 of err_o are set on the next cycle. Bits 11:8 hold the lowest channel number that has a twin. The word stays until err_clr_i, and the named channel does not change while the word is set.
- R10: Control bit 2 written high halts all grants, and written low releases them. While control bit 1 (halt on error) is set, a duplicate level sets halt on the same cycle as the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Hardware request per channel |
| busy_i | input | 1 | Transfer engine busy |
| done_i | input | 1 | Channel in service has finished |
| ctl_wr_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 3 | Bit 0 rotating mode, bit 1 halt on error, bit 2 halt |
| en_set_wr_i | input | 1 | Apply en_cmd_i as a set-enable command |
| en_clr_wr_i | input | 1 | Apply en_cmd_i as a clear-enable command |
| en_cmd_i | input | 8 | Enable command byte |
| pri_wr_i | input | 1 | Write strobe for a priority byte |
| pri_sel_i | input | 4 | Channel whose priority byte is written |
| pri_wdata_i | input | 8 | Bits 3:0 level, bit 6 no-preempt-others, bit 7 preemptible |
| err_clr_i | input | 1 | Clear the error word |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_ch_o | output | 4 | Channel of the latest grant |
| preempt_o | output | 1 | The current grant displaces the channel in service |
| en_o | output | 16 | Current enable mask |
| halt_o | output | 1 | Grants halted |
| err_o | output | 32 | Error word: bit 31 summary, bit 14 duplicate level, bits 11:8 channel |

## Verification
The hard collision is a done pulse that lands in the same cycle as a request that would otherwise preempt the channel in service. Arbitration and service-release then compete for one edge. The bench sets up this case by hand: a preemptible channel is in service when a stronger request arrives together with done_i. It expects no grant on that cycle and an ordinary grant with preempt_o low on the next. Random traffic also produces done, busy, command writes and priority writes in the same cycle many times. Every cycle is compared with a reference model that applies the requirements' ordering rules.

// File: rtl/dma_arb_pkg.sv
// Shared constants and types for the DMA channel arbiter.
package dma_arb_pkg;
    localparam int CMD_W          = 8;
    localparam int CMD_ALL_BIT    = 6;
    localparam int CMD_NOP_BIT    = 7;
    localparam int PRI_NOPRE_BIT  = 6;
    localparam int PRI_YIELD_BIT  = 7;
    localparam int CTL_W          = 3;
    localparam int CTL_RR_BIT     = 0;
    localparam int CTL_HOE_BIT    = 1;
    localparam int CTL_HALT_BIT   = 2;
    localparam int ERR_W          = 32;
    localparam int ERR_VLD_BIT    = 31;
    localparam int ERR_DUP_BIT    = 14;
    localparam int ERR_CHN_LSB    = 8;

    typedef struct packed {
        logic halt;
        logic hoe;
        logic rr;
    } arb_ctl_t;
endpackage

// File: rtl/dma_arb_enable.sv
// Enable mask with byte-wide set/clear commands.
// Assumes the command byte selects a channel with its low CW bits.
// A set and a clear in the same cycle resolve in favour of the clear.
module dma_arb_enable
    import dma_arb_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr_i,
    input  logic             clr_wr_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic [NCH-1:0]   en_o
);
    logic [NCH-1:0] set_m;
    logic [NCH-1:0] clr_m;
    logic           unused_cmd_bits;

    assign unused_cmd_bits = ^cmd_i[CMD_ALL_BIT-1:CW];

    // Decode one command byte into a channel mask.
    function automatic logic [NCH-1:0] cmd_mask(input logic [CMD_W-1:0] c);
        logic [NCH-1:0] m;
        m = '0;
        if (!c[CMD_NOP_BIT]) begin
            if (c[CMD_ALL_BIT]) m = '1;
            else                m[c[CW-1:0]] = 1'b1;
        end
        return m;
    endfunction

    // Masks for this cycle's commands.
    always_comb begin
        set_m = set_wr_i ? cmd_mask(cmd_i) : '0;
        clr_m = clr_wr_i ? cmd_mask(cmd_i) : '0;
    end

    // Enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n) en_o <= '0;
        else        en_o <= (en_o | set_m) & ~clr_m;
    end
endmodule

// File: rtl/dma_arb_prio.sv
// Per-channel priority bank and duplicate-level detector.
// Assumes one priority byte is written per cycle. Reset gives channel n level n.
module dma_arb_prio
    import dma_arb_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4,
    parameter int PW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [CW-1:0]           sel_i,
    input  logic [CMD_W-1:0]        wdata_i,
    output logic [NCH-1:0][PW-1:0]  level_o,
    output logic [NCH-1:0]          yield_o,
    output logic [NCH-1:0]          nopre_o,
    output logic [NCH-1:0]          dup_o
);
    logic unused_pri_bits;
    assign unused_pri_bits = ^wdata_i[PRI_NOPRE_BIT-1:PW];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Store one channel's level and flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_o[g] <= PW'(g);
                yield_o[g] <= 1'b0;
                nopre_o[g] <= 1'b0;
            end else if (wr_i && sel_i == CW'(g)) begin
                level_o[g] <= wdata_i[PW-1:0];
                yield_o[g] <= wdata_i[PRI_YIELD_BIT];
                nopre_o[g] <= wdata_i[PRI_NOPRE_BIT];
            end
        end

        // Flag this channel when another channel shares its level.
        always_comb begin
            dup_o[g] = 1'b0;
            for (int m = 0; m < NCH; m++) begin
                if (m != g && level_o[m] == level_o[g]) dup_o[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_arb_pick.sv
// Combinational winner search. It gives both a fixed-priority pick and a
// rotating pick. Assumes elig_i is already masked by the enables.
module dma_arb_pick #(
    parameter int NCH = 16,
    parameter int CW  = 4,
    parameter int PW  = 4
) (
    input  logic [NCH-1:0]          elig_i,
    input  logic [NCH-1:0][PW-1:0]  level_i,
    input  logic [CW-1:0]           last_i,
    output logic [CW-1:0]           fx_idx_o,
    output logic                    fx_found_o,
    output logic [CW-1:0]           rr_idx_o,
    output logic                    rr_found_o
);
    logic [PW-1:0] best;

    // Highest level wins. A strict compare keeps the lower index on ties.
    always_comb begin
        fx_found_o = 1'b0;
        fx_idx_o   = '0;
        best       = '0;
        for (int n = 0; n < NCH; n++) begin
            if (elig_i[n] && (!fx_found_o || level_i[n] > best)) begin
                fx_found_o = 1'b1;
                fx_idx_o   = CW'(n);
                best       = level_i[n];
            end
        end
    end

    // First eligible channel after last_i, wrapping round.
    always_comb begin
        int idx;
        rr_found_o = 1'b0;
        rr_idx_o   = '0;
        for (int k = 0; k < NCH; k++) begin
            idx = (int'(last_i) + 1 + k) % NCH;
            if (!rr_found_o && elig_i[idx]) begin
                rr_found_o = 1'b1;
                rr_idx_o   = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
// DMA channel arbiter top. It holds the control register, the service
// tracking, the grant register and the duplicate-level error word.
// Assumes done_i only refers to the channel in service and that
// NCH <= 16, so the channel fits in error bits 11:8.
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NCH = 16,
    parameter  int PW  = 4,
    localparam int CW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              ctl_wr_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic              en_set_wr_i,
    input  logic              en_clr_wr_i,
    input  logic [CMD_W-1:0]  en_cmd_i,
    input  logic              pri_wr_i,
    input  logic [CW-1:0]     pri_sel_i,
    input  logic [CMD_W-1:0]  pri_wdata_i,
    input  logic              err_clr_i,
    output logic              grant_valid_o,
    output logic [CW-1:0]     grant_ch_o,
    output logic              preempt_o,
    output logic [NCH-1:0]    en_o,
    output logic              halt_o,
    output logic [ERR_W-1:0]  err_o
);
    logic [NCH-1:0][PW-1:0] level;
    logic [NCH-1:0]         yield_f;
    logic [NCH-1:0]         nopre_f;
    logic [NCH-1:0]         dup;
    logic [NCH-1:0]         elig;
    logic [CW-1:0]          fx_idx, rr_idx, win;
    logic                   fx_found, rr_found, found;
    arb_ctl_t               ctl_q;
    logic                   rr_mode;
    logic                   act_q;
    logic [CW-1:0]          act_ch_q;
    logic [CW-1:0]          last_q;
    logic                   dup_q;
    logic [CW-1:0]          dup_ch_q;
    logic                   any_dup;
    logic [CW-1:0]          dup_lo;
    logic                   take_normal, take_pre;

    dma_arb_enable #(.NCH(NCH), .CW(CW)) u_en (
        .clk(clk), .rst_n(rst_n), .set_wr_i(en_set_wr_i), .clr_wr_i(en_clr_wr_i),
        .cmd_i(en_cmd_i), .en_o(en_o)
    );

    dma_arb_prio #(.NCH(NCH), .CW(CW), .PW(PW)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_i(pri_wr_i), .sel_i(pri_sel_i),
        .wdata_i(pri_wdata_i), .level_o(level), .yield_o(yield_f),
        .nopre_o(nopre_f), .dup_o(dup)
    );

    assign elig    = req_i & en_o;
    assign rr_mode = ctl_q.rr;

    dma_arb_pick #(.NCH(NCH), .CW(CW), .PW(PW)) u_pick (
        .elig_i(elig), .level_i(level), .last_i(last_q),
        .fx_idx_o(fx_idx), .fx_found_o(fx_found),
        .rr_idx_o(rr_idx), .rr_found_o(rr_found)
    );

    // Lowest channel that shares its level with another channel.
    always_comb begin
        any_dup = |dup;
        dup_lo  = '0;
        for (int n = NCH - 1; n >= 0; n--) begin
            if (dup[n]) dup_lo = CW'(n);
        end
    end

    // Grant decision for this cycle.
    always_comb begin
        win         = rr_mode ? rr_idx : fx_idx;
        found       = rr_mode ? rr_found : fx_found;
        take_normal = !ctl_q.halt && !busy_i && !act_q && found;
        take_pre    = !rr_mode && !ctl_q.halt && act_q && !done_i && fx_found
                      && yield_f[act_ch_q] && !nopre_f[fx_idx]
                      && (level[fx_idx] > level[act_ch_q]);
    end

    // Control register. Halt on error overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr_i) begin
                ctl_q.rr   <= ctl_wdata_i[CTL_RR_BIT];
                ctl_q.hoe  <= ctl_wdata_i[CTL_HOE_BIT];
                ctl_q.halt <= ctl_wdata_i[CTL_HALT_BIT];
            end
            if (ctl_q.hoe && any_dup) ctl_q.halt <= 1'b1;
        end
    end

    // Grant outputs, service tracking and the rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_o <= 1'b0;
            grant_ch_o    <= '0;
            preempt_o     <= 1'b0;
            act_q         <= 1'b0;
            act_ch_q      <= '0;
            last_q        <= CW'(NCH - 1);
        end else begin
            grant_valid_o <= take_normal || take_pre;
            preempt_o     <= take_pre;
            if (take_normal || take_pre) begin
                grant_ch_o <= win;
                act_q      <= 1'b1;
                act_ch_q   <= win;
                last_q     <= win;
            end else if (done_i) begin
                act_q      <= 1'b0;
            end
        end
    end

    // Sticky duplicate-level error. The channel is captured on the first detection.
    always_ff @(posedge clk) begin
        if (!rst_n || err_clr_i) begin
            dup_q    <= 1'b0;
            dup_ch_q <= '0;
        end else if (!dup_q && any_dup) begin
            dup_q    <= 1'b1;
            dup_ch_q <= dup_lo;
        end
    end

    // Assemble the error word and the halt output.
    always_comb begin
        err_o                      = '0;
        err_o[ERR_VLD_BIT]         = dup_q;
        err_o[ERR_DUP_BIT]         = dup_q;
        err_o[ERR_CHN_LSB +: CW]   = dup_ch_q;
        halt_o                     = ctl_q.halt;
    end
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
// Property checker for dma_chan_arbiter, attached by bind.
module dma_chan_arbiter_chk #(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req_i,
    input logic [NCH-1:0] en_o,
    input logic           grant_valid_o,
    input logic [CW-1:0]  grant_ch_o,
    input logic           preempt_o,
    input logic           halt_o,
    input logic           rr_mode,
    input logic [31:0]    err_o,
    input logic           err_clr_i,
    input logic           en_set_wr_i,
    input logic           en_clr_wr_i,
    input logic [7:0]     en_cmd_i
);
    logic [NCH-1:0] elig_q;

    // Eligibility seen on the edge where the grant was decided.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= req_i & en_o;
    end

    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> elig_q[grant_ch_o]);

    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |=> (!grant_valid_o || preempt_o));

    p_preempt_is_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> grant_valid_o);

    p_preempt_fixed_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> !$past(rr_mode));

    p_nop_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_wr_i && !en_clr_wr_i && en_cmd_i[7]) |=> $stable(en_o));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o[31] && !err_clr_i) |=> (err_o[31] && $stable(err_o[11:8])));

    p_halt_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt_o) |-> !grant_valid_o);
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NCH(NCH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_o(en_o),
    .grant_valid_o(grant_valid_o), .grant_ch_o(grant_ch_o),
    .preempt_o(preempt_o), .halt_o(halt_o), .rr_mode(rr_mode),
    .err_o(err_o), .err_clr_i(err_clr_i), .en_set_wr_i(en_set_wr_i),
    .en_clr_wr_i(en_clr_wr_i), .en_cmd_i(en_cmd_i)
);

// File: tb/dma_chan_arbiter_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, checked every cycle
// against a reference model written from the requirements.
module dma_chan_arbiter_tb_top;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_i;
    logic        busy_i, done_i, ctl_wr_i, en_set_wr_i, en_clr_wr_i;
    logic        pri_wr_i, err_clr_i;
    logic [2:0]  ctl_wdata_i;
    logic [7:0]  en_cmd_i, pri_wdata_i;
    logic [3:0]  pri_sel_i;
    logic        grant_valid_o, preempt_o, halt_o;
    logic [3:0]  grant_ch_o;
    logic [15:0] en_o;
    logic [31:0] err_o;

    always #5 clk = ~clk;

    dma_chan_arbiter #(.NCH(NCH), .PW(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_i(busy_i), .done_i(done_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .en_set_wr_i(en_set_wr_i),
        .en_clr_wr_i(en_clr_wr_i), .en_cmd_i(en_cmd_i), .pri_wr_i(pri_wr_i),
        .pri_sel_i(pri_sel_i), .pri_wdata_i(pri_wdata_i), .err_clr_i(err_clr_i),
        .grant_valid_o(grant_valid_o), .grant_ch_o(grant_ch_o), .preempt_o(preempt_o),
        .en_o(en_o), .halt_o(halt_o), .err_o(err_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    logic [15:0] m_en, m_yield, m_nopre;
    logic [3:0]  m_lvl [16];
    logic        m_act, m_rr, m_hoe, m_halt, m_cpe, m_gv, m_pre;
    logic [3:0]  m_actch, m_last, m_chn, m_gch;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_mask(input logic [7:0] c);
        logic [15:0] m = '0;
        if (!c[7]) begin
            if (c[6]) m = '1;
            else      m[c[3:0]] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] f_err();
        logic [31:0] e = '0;
        e[31] = m_cpe;
        e[14] = m_cpe;
        e[11:8] = m_chn;
        return e;
    endfunction

    task automatic model_reset();
        m_en = '0; m_yield = '0; m_nopre = '0;
        for (int n = 0; n < 16; n++) m_lvl[n] = 4'(n);
        m_act = 0; m_rr = 0; m_hoe = 0; m_halt = 0; m_cpe = 0; m_gv = 0; m_pre = 0;
        m_actch = 0; m_last = 4'd15; m_chn = 0; m_gch = 0;
    endtask

    // Next state from the current model state and the driven inputs.
    task automatic model_step();
        logic [15:0] elig, dup, sm, cm;
        logic [3:0]  fidx, ridx, lo, win;
        logic        ff, rf, found, normal, pre, hoe_old;
        elig = req_i & m_en;
        dup = '0;
        for (int n = 0; n < 16; n++)
            for (int m = 0; m < 16; m++)
                if (m != n && m_lvl[m] == m_lvl[n]) dup[n] = 1'b1;
        lo = 0;
        for (int n = 15; n >= 0; n--) if (dup[n]) lo = 4'(n);
        ff = 0; fidx = 0;
        for (int n = 0; n < 16; n++)
            if (elig[n] && (!ff || m_lvl[n] > m_lvl[fidx])) begin ff = 1; fidx = 4'(n); end
        rf = 0; ridx = 0;
        for (int k = 1; k <= 16; k++) begin
            int idx = (int'(m_last) + k) % 16;
            if (!rf && elig[idx]) begin rf = 1; ridx = 4'(idx); end
        end
        win = m_rr ? ridx : fidx;
        found = m_rr ? rf : ff;
        normal = !m_halt && !busy_i && !m_act && found;
        pre = !m_rr && !m_halt && m_act && !done_i && ff && m_yield[m_actch]
              && !m_nopre[fidx] && (m_lvl[fidx] > m_lvl[m_actch]);
        m_gv = normal || pre;
        m_pre = pre;
        if (m_gv) begin
            m_gch = win; m_last = win; m_act = 1; m_actch = win;
        end else if (done_i) m_act = 0;
        sm = en_set_wr_i ? f_mask(en_cmd_i) : '0;
        cm = en_clr_wr_i ? f_mask(en_cmd_i) : '0;
        if (err_clr_i) begin m_cpe = 0; m_chn = 0; end
        else if (!m_cpe && |dup) begin m_cpe = 1; m_chn = lo; end
        hoe_old = m_hoe;
        if (ctl_wr_i) begin m_rr = ctl_wdata_i[0]; m_hoe = ctl_wdata_i[1]; m_halt = ctl_wdata_i[2]; end
        if (hoe_old && |dup) m_halt = 1;
        m_en = (m_en | sm) & ~cm;
        if (pri_wr_i) begin
            m_lvl[pri_sel_i] = pri_wdata_i[3:0];
            m_yield[pri_sel_i] = pri_wdata_i[7];
            m_nopre[pri_sel_i] = pri_wdata_i[6];
        end
    endtask

    // One clock: update the model, then compare every output away from the edge.
    task automatic tick();
        model_step();
        @(negedge clk);
        chk("R5", "grant_valid", 32'(grant_valid_o), 32'(m_gv));
        chk(m_rr ? "R4" : "R3", "grant_ch", 32'(grant_ch_o), 32'(m_gch));
        chk("R6", "preempt", 32'(preempt_o), 32'(m_pre));
        chk("R8", "enable", 32'(en_o), 32'(m_en));
        chk("R10", "halt", 32'(halt_o), 32'(m_halt));
        chk("R9", "error", err_o, f_err());
    endtask

    task automatic serve();
        req_i = '0; done_i = 1; tick(); done_i = 0;
    endtask

    task automatic pri(input logic [3:0] ch, input logic [7:0] d);
        pri_wr_i = 1; pri_sel_i = ch; pri_wdata_i = d; tick(); pri_wr_i = 0;
    endtask

    task automatic ctl(input logic [2:0] d);
        ctl_wr_i = 1; ctl_wdata_i = d; tick(); ctl_wr_i = 0;
    endtask

    task automatic en_cmd(input logic s, input logic c, input logic [7:0] d);
        en_set_wr_i = s; en_clr_wr_i = c; en_cmd_i = d; tick();
        en_set_wr_i = 0; en_clr_wr_i = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 0; req_i = 0; busy_i = 0; done_i = 0; ctl_wr_i = 0; ctl_wdata_i = 0;
        en_set_wr_i = 0; en_clr_wr_i = 0; en_cmd_i = 0; pri_wr_i = 0; pri_sel_i = 0;
        pri_wdata_i = 0; err_clr_i = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: state right after reset
        chk("R1", "enable", 32'(en_o), 0);
        chk("R1", "grant_valid", 32'(grant_valid_o), 0);
        chk("R1", "error", err_o, 0);
        chk("R1", "halt", 32'(halt_o), 0);

        // R8: no-op outranks all-channels, all-set, single clear, clear wins
        en_cmd(1, 0, 8'hC5); chk("R8", "nop enable", 32'(en_o), 0);
        en_cmd(1, 0, 8'h45); chk("R8", "set all", 32'(en_o), 32'hFFFF);
        en_cmd(0, 1, 8'h05); chk("R8", "clear one", 32'(en_o), 32'hFFDF);
        en_cmd(1, 1, 8'h05); chk("R8", "set+clear", 32'(en_o), 32'hFFDF);

        // R2: request without enable gives nothing, then enable lets it through
        req_i = 16'h0020; tick(); tick();
        chk("R2", "disabled grant", 32'(grant_valid_o), 0);
        en_cmd(1, 0, 8'h05);
        tick();
        chk("R2", "enabled grant", {grant_valid_o, grant_ch_o}, {1'b1, 4'd5});
        serve();

        // R3: highest level, then tie to lower index
        req_i = 16'h0813; tick();
        chk("R3", "highest level", 32'(grant_ch_o), 11);
        serve();
        pri(4'd1, 8'h0B);
        req_i = 16'h0802; tick();
        chk("R3", "tie lower index", 32'(grant_ch_o), 1);
        serve();
        pri(4'd1, 8'h01);
        err_clr_i = 1; tick(); err_clr_i = 0; tick();
        chk("R9", "cleared", err_o, 0);

        // R4: rotation after last grant with wrap
        ctl(3'b001);
        req_i = 16'h8003; tick();
        chk("R4", "after last", 32'(grant_ch_o), 15);
        serve();
        req_i = 16'h8003; tick();
        chk("R4", "wrap", 32'(grant_ch_o), 0);
        serve();
        ctl(3'b000);

        // R6: preemption allowed, then blocked by no-preempt-others
        pri(4'd2, 8'h82);
        req_i = 16'h0004; tick();
        req_i = 16'h0204; busy_i = 1; tick();
        chk("R6", "preempt", {grant_valid_o, preempt_o, grant_ch_o}, {1'b1, 1'b1, 4'd9});
        busy_i = 0; serve();
        pri(4'd9, 8'h49);
        req_i = 16'h0004; tick();
        req_i = 16'h0204; tick();
        chk("R6", "blocked preempt", 32'(grant_valid_o), 0);
        serve();
        pri(4'd9, 8'h09);

        // R7: done in the same cycle as a preemption condition
        req_i = 16'h0004; tick();
        req_i = 16'h0204; done_i = 1; tick();
        chk("R7", "no preempt on done", {grant_valid_o, preempt_o}, 0);
        done_i = 0; tick();
        chk("R7", "normal grant after", {grant_valid_o, preempt_o, grant_ch_o}, {1'b1, 1'b0, 4'd9});
        serve();

        // R5: engine busy holds off the grant
        req_i = 16'h0004; busy_i = 1; tick(); tick();
        chk("R5", "busy", 32'(grant_valid_o), 0);
        busy_i = 0; tick();
        chk("R5", "released", {grant_valid_o, grant_ch_o}, {1'b1, 4'd2});
        serve();

        // R9/R10: duplicate level with halt on error
        ctl(3'b010);
        pri(4'd7, 8'h05);
        tick();
        chk("R9", "dup word", err_o, 32'h8000_4500);
        chk("R10", "halt on error", 32'(halt_o), 1);
        req_i = 16'h0001; tick(); tick();
        chk("R10", "halted grant", 32'(grant_valid_o), 0);
        req_i = 0;
        pri(4'd7, 8'h07);
        err_clr_i = 1; ctl(3'b000); err_clr_i = 0;
        tick();
        chk("R10", "unhalted", 32'(halt_o), 0);
        chk("R9", "clear", err_o, 0);

        // Seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            req_i = 16'($urandom);
            if ($urandom % 3 == 0) req_i &= 16'($urandom);
            busy_i = ($urandom % 4 == 0);
            done_i = ($urandom % 5 == 0);
            en_set_wr_i = ($urandom % 6 == 0);
            en_clr_wr_i = ($urandom % 8 == 0);
            en_cmd_i = 8'($urandom);
            pri_wr_i = ($urandom % 25 == 0);
            pri_sel_i = 4'($urandom);
            pri_wdata_i = ($urandom % 3 == 0) ? 8'($urandom)
                        : {2'($urandom), 2'b00, pri_sel_i};
            ctl_wr_i = ($urandom % 40 == 0);
            ctl_wdata_i = 3'($urandom) & (($urandom % 4 == 0) ? 3'b111 : 3'b011);
            err_clr_i = ($urandom % 15 == 0);
            tick();
        end
        summary();
        $finish;
    end
endmodule